// File: doc/BRIEF.md
# NAND Controller Register and Interrupt Front End

This block is the software-visible control face of a NAND flash controller. It sits on a simple 32-bit register bus with one-cycle write and read strobes and a combinational read path. It holds the flash interface configuration, the access timing fields and a chip-enable control bit, and it exports all of them to the flash sequencer. It also turns command-register and address-register writes into byte strobes for that sequencer.

The configuration and timing registers are guarded by a key. Software first writes the key to the lock word. It then has exactly one write into a guarded register, after which the guard closes again by itself.

Events reported by the sequencer are latched into an interrupt status word that clears when it is read. The events are rising edges of the NAND-ready and controller-ready levels, decode completion with its outcome, and write-protect faults. A level-high interrupt line is raised while any latched event is enabled by the mask. A raw status word shows the live ready levels and the most recent decode outcome.

Top module: `nfc_reg_front`

## Requirements
- R1: Writing the full word 0x0000A25E to the lock word (word index 7) opens the guard, and reading that word then returns 1 in bit 0. A write of any other value to the lock word closes the guard, so reading it returns 0.
- R2: While the guard is open, one write to a guarded word (configuration, index 2, or timing, index 3) takes effect and closes the guard in the same cycle, with no further software action.
- R3: A write to a guarded word while the guard is closed changes neither that word nor the guard state.
- R4: Configuration bits map as follows: bit 0 selects the 16-bit bus, bit 1 the five-byte address, bit 2 large-block devices and bit 3 write protect. Timing fields map as follows: write-low 3:0, write-high 7:4, read-low 11:8, read-high 15:12, turnaround 18:16, busy delay 23:19 and chip-enable access delay 25:24. Each field appears on its own output from the cycle after the accepted write, and the word reads back unchanged.
- R5: The interrupt status word (index 5) has this layout: bit 0 write-protect fault, bit 1 ECC ready, bit 2 decode error, bit 3 decode failure, bit 4 controller ready, bit 5 NAND ready. A read returns the latched events and clears them at that edge. Each ready bit latches only on a rising edge of its level.
- R6: The interrupt line is high exactly while the latched status ANDed with the mask word (index 4, same layout) is nonzero. The mask never stops an event from latching.
- R7: An event arriving in the same cycle as a clearing read is not lost; it is returned by the next read.
- R8: The raw status word (index 6) has this layout: bit 0 the live NAND-ready level, bit 1 the live controller-ready level, bit 2 ECC ready, bit 3 errors detected, bits 5:4 the corrected-error count minus one, and bit 6 decode failure. Bits 2 to 6 are captured on each decode-done pulse and held until the next one.
- R9: A write to the command word (index 0) with low byte 0xFF gives a one-cycle controller reset pulse and no command strobe. It clears the latched events and the captured decode result. Any other command byte gives a one-cycle command strobe carrying that byte. A write to the address word (index 1) gives a one-cycle address strobe carrying its byte.
- R10: Bit 0 of the chip-enable word (index 8) drives the output that leaves chip enable under controller control.
- R11: After reset the guard is closed, and configuration, timing, mask, chip-enable control, latched events, decode result and all strobes are zero, with the interrupt line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while bus_re_i is high |
| sq_nand_rdy_i | input | 1 | NAND ready level from the sequencer |
| sq_ctl_rdy_i | input | 1 | Controller ready level from the sequencer |
| sq_dec_done_i | input | 1 | Decode complete pulse |
| sq_dec_err_i | input | 1 | Correctable errors were found (with done) |
| sq_dec_fail_i | input | 1 | Decode failed (with done) |
| sq_dec_cnt_i | input | 2 | Corrected errors minus one (with done) |
| sq_wp_fault_i | input | 1 | Write-protect fault pulse |
| irq_o | output | 1 | Level-high interrupt |
| seq_rst_o | output | 1 | Controller reset pulse |
| seq_cmd_stb_o | output | 1 | Command byte strobe |
| seq_adr_stb_o | output | 1 | Address byte strobe |
| seq_code_o | output | 8 | Command or address byte |
| cfg_bus16_o | output | 1 | 16-bit bus select |
| cfg_longadr_o | output | 1 | Five-byte address select |
| cfg_bigblk_o | output | 1 | Large-block device select |
| cfg_wprot_o | output | 1 | Write protect |
| tm_wr_lo_o | output | 4 | Write strobe low time |
| tm_wr_hi_o | output | 4 | Write strobe high time |
| tm_rd_lo_o | output | 4 | Read strobe low time |
| tm_rd_hi_o | output | 4 | Read strobe high time |
| tm_turn_o | output | 3 | Bus turnaround time |
| tm_busy_o | output | 5 | Busy delay |
| tm_cea_o | output | 2 | Chip-enable access delay |
| ce_auto_o | output | 1 | Chip enable under controller control |

## Verification
A guard stuck open or failing to close shows at the next lock-word read and as a timing or configuration output that moves when it should not, one cycle after the offending write. A lost or doubled event, or one cleared by the mask, shows on the interrupt line in the cycle after the event or the read, and in the next status read. A stale or wrongly packed decode result shows at once in the raw status word. A misrouted reset or command byte shows on the strobe outputs in the cycle after the command write.

// File: rtl/nfc_regs_pkg.sv
package nfc_regs_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_EV  = 6;
    localparam int CFG_W   = 4;
    localparam int TIM_W   = 26;
    localparam logic [WORD_W-1:0] GUARD_KEY = 32'h0000_A25E;
    localparam logic [7:0] RESET_OP = 8'hFF;

    // word indices
    localparam int RG_CMD  = 0;
    localparam int RG_ADR  = 1;
    localparam int RG_CFG  = 2;
    localparam int RG_TIM  = 3;
    localparam int RG_MASK = 4;
    localparam int RG_STAT = 5;
    localparam int RG_RAW  = 6;
    localparam int RG_KEY  = 7;
    localparam int RG_CE   = 8;

    // event bit positions (shared by mask and status)
    localparam int EV_WP   = 0;
    localparam int EV_ECC  = 1;
    localparam int EV_DERR = 2;
    localparam int EV_DFAIL= 3;
    localparam int EV_CTL  = 4;
    localparam int EV_NAND = 5;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [TIM_W-1:0]  tim;
        logic [NUM_EV-1:0] mask;
        logic              ce;
        logic              dec_ok;
        logic              dec_err;
        logic [1:0]        dec_cnt;
        logic              dec_fail;
        logic              rst_stb;
        logic              cmd_stb;
        logic              adr_stb;
        logic [7:0]        code;
    } front_t;

endpackage

// File: rtl/nfc_key_lock.sv
module nfc_key_lock #(
    parameter int KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY = KEY_W'(32'h0000_A25E)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             key_wr_i,
    input  logic [KEY_W-1:0] key_data_i,
    input  logic             prot_wr_i,
    output logic             open_o,
    output logic             accept_o
);

    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (key_wr_i) begin
            open_d = (key_data_i == KEY);
        end else if (prot_wr_i && open_q) begin
            open_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) open_q <= 1'b0;
        else         open_q <= open_d;
    end

    assign open_o   = open_q;
    assign accept_o = prot_wr_i && open_q;

endmodule

// File: rtl/nfc_rise_det.sv
module nfc_rise_det #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_d, prev_q;

        always_comb prev_d = lvl_i[i];

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= prev_d;
        end

        assign rise_o[i] = lvl_i[i] && !prev_q;
    end

endmodule

// File: rtl/nfc_event_latch.sv
module nfc_event_latch #(
    parameter int N = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] ev_i,
    input  logic         clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] stat_o,
    output logic         irq_o
);

    logic [N-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_i) stat_d = '0;
        // set wins over clear so a coincident event survives
        stat_d = stat_d | ev_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= stat_d;
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & mask_i);

endmodule

// File: rtl/nfc_reg_front.sv
module nfc_reg_front
    import nfc_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              sq_nand_rdy_i,
    input  logic              sq_ctl_rdy_i,
    input  logic              sq_dec_done_i,
    input  logic              sq_dec_err_i,
    input  logic              sq_dec_fail_i,
    input  logic [1:0]        sq_dec_cnt_i,
    input  logic              sq_wp_fault_i,
    output logic              irq_o,
    output logic              seq_rst_o,
    output logic              seq_cmd_stb_o,
    output logic              seq_adr_stb_o,
    output logic [7:0]        seq_code_o,
    output logic              cfg_bus16_o,
    output logic              cfg_longadr_o,
    output logic              cfg_bigblk_o,
    output logic              cfg_wprot_o,
    output logic [3:0]        tm_wr_lo_o,
    output logic [3:0]        tm_wr_hi_o,
    output logic [3:0]        tm_rd_lo_o,
    output logic [3:0]        tm_rd_hi_o,
    output logic [2:0]        tm_turn_o,
    output logic [4:0]        tm_busy_o,
    output logic [1:0]        tm_cea_o,
    output logic              ce_auto_o
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(RG_CMD);
    localparam logic [ADDR_W-1:0] A_ADR  = ADDR_W'(RG_ADR);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(RG_CFG);
    localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(RG_TIM);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(RG_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RG_STAT);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RG_RAW);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(RG_KEY);
    localparam logic [ADDR_W-1:0] A_CE   = ADDR_W'(RG_CE);

    front_t r_d, r_q;

    logic key_open, prot_ok, prot_wr, key_wr, stat_clr, rst_cmd;
    logic [1:0] rdy_lvl, rdy_rise;
    logic [NUM_EV-1:0] ev_vec, ev_mask, ev_stat;

    assign key_wr  = bus_we_i && (bus_addr_i == A_KEY);
    assign prot_wr = bus_we_i && ((bus_addr_i == A_CFG) || (bus_addr_i == A_TIM));
    assign rst_cmd = bus_we_i && (bus_addr_i == A_CMD) && (bus_wdata_i[7:0] == RESET_OP);

    nfc_key_lock #(
        .KEY_W (WORD_W),
        .KEY   (GUARD_KEY)
    ) lock_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .key_wr_i   (key_wr),
        .key_data_i (bus_wdata_i),
        .prot_wr_i  (prot_wr),
        .open_o     (key_open),
        .accept_o   (prot_ok)
    );

    assign rdy_lvl = {sq_nand_rdy_i, sq_ctl_rdy_i};

    nfc_rise_det #(.N(2)) rise_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (rdy_lvl),
        .rise_o (rdy_rise)
    );

    always_comb begin
        ev_vec           = '0;
        ev_vec[EV_WP]    = sq_wp_fault_i;
        ev_vec[EV_ECC]   = sq_dec_done_i;
        ev_vec[EV_DERR]  = sq_dec_done_i && sq_dec_err_i;
        ev_vec[EV_DFAIL] = sq_dec_done_i && sq_dec_fail_i;
        ev_vec[EV_CTL]   = rdy_rise[0];
        ev_vec[EV_NAND]  = rdy_rise[1];
    end

    assign stat_clr = (bus_re_i && (bus_addr_i == A_STAT)) || rst_cmd;
    assign ev_mask  = r_q.mask;

    nfc_event_latch #(.N(NUM_EV)) evl_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (ev_vec),
        .clr_i  (stat_clr),
        .mask_i (ev_mask),
        .stat_o (ev_stat),
        .irq_o  (irq_o)
    );

    // next-state for the register file
    always_comb begin
        r_d         = r_q;
        r_d.rst_stb = 1'b0;
        r_d.cmd_stb = 1'b0;
        r_d.adr_stb = 1'b0;

        if (bus_we_i) begin
            case (bus_addr_i)
                A_CMD: begin
                    r_d.code = bus_wdata_i[7:0];
                    if (bus_wdata_i[7:0] == RESET_OP) r_d.rst_stb = 1'b1;
                    else                              r_d.cmd_stb = 1'b1;
                end
                A_ADR: begin
                    r_d.code    = bus_wdata_i[7:0];
                    r_d.adr_stb = 1'b1;
                end
                A_CFG:  if (prot_ok) r_d.cfg = bus_wdata_i[CFG_W-1:0];
                A_TIM:  if (prot_ok) r_d.tim = bus_wdata_i[TIM_W-1:0];
                A_MASK: r_d.mask = bus_wdata_i[NUM_EV-1:0];
                A_CE:   r_d.ce   = bus_wdata_i[0];
                default: ;
            endcase
        end

        if (rst_cmd) begin
            r_d.dec_ok   = 1'b0;
            r_d.dec_err  = 1'b0;
            r_d.dec_cnt  = '0;
            r_d.dec_fail = 1'b0;
        end
        if (sq_dec_done_i) begin
            r_d.dec_ok   = 1'b1;
            r_d.dec_err  = sq_dec_err_i;
            r_d.dec_cnt  = sq_dec_cnt_i;
            r_d.dec_fail = sq_dec_fail_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    // read path
    always_comb begin
        bus_rdata_o = '0;
        if (bus_re_i) begin
            case (bus_addr_i)
                A_CFG:  bus_rdata_o = 32'(r_q.cfg);
                A_TIM:  bus_rdata_o = 32'(r_q.tim);
                A_MASK: bus_rdata_o = 32'(r_q.mask);
                A_STAT: bus_rdata_o = 32'(ev_stat);
                A_RAW:  bus_rdata_o = 32'({r_q.dec_fail, r_q.dec_cnt, r_q.dec_err,
                                           r_q.dec_ok, sq_ctl_rdy_i, sq_nand_rdy_i});
                A_KEY:  bus_rdata_o = 32'(key_open);
                A_CE:   bus_rdata_o = 32'(r_q.ce);
                default: bus_rdata_o = '0;
            endcase
        end
    end

    assign seq_rst_o     = r_q.rst_stb;
    assign seq_cmd_stb_o = r_q.cmd_stb;
    assign seq_adr_stb_o = r_q.adr_stb;
    assign seq_code_o    = r_q.code;
    assign cfg_bus16_o   = r_q.cfg[0];
    assign cfg_longadr_o = r_q.cfg[1];
    assign cfg_bigblk_o  = r_q.cfg[2];
    assign cfg_wprot_o   = r_q.cfg[3];
    assign tm_wr_lo_o    = r_q.tim[3:0];
    assign tm_wr_hi_o    = r_q.tim[7:4];
    assign tm_rd_lo_o    = r_q.tim[11:8];
    assign tm_rd_hi_o    = r_q.tim[15:12];
    assign tm_turn_o     = r_q.tim[18:16];
    assign tm_busy_o     = r_q.tim[23:19];
    assign tm_cea_o      = r_q.tim[25:24];
    assign ce_auto_o     = r_q.ce;

endmodule

// File: rtl/nfc_reg_front_chk.sv
module nfc_reg_front_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_we_i,
    input logic              bus_re_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic              guard_open,
    input logic [5:0]        mask,
    input logic [3:0]        cfg,
    input logic              sq_nand_rdy_i,
    input logic              sq_ctl_rdy_i,
    input logic              sq_dec_done_i,
    input logic              sq_wp_fault_i,
    input logic              irq_o,
    input logic              seq_rst_o,
    input logic              seq_cmd_stb_o
);

    // R1: the key opens the guard
    a_r1_key_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(7) && bus_wdata_i == 32'h0000_A25E) |=> guard_open);

    // R2: one guarded write closes the guard
    a_r2_auto_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && (bus_addr_i == ADDR_W'(2) || bus_addr_i == ADDR_W'(3)) && guard_open)
        |=> !guard_open);

    // R3: a closed guard keeps configuration unchanged
    a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(2) && !guard_open) |=> ($stable(cfg) && !guard_open));

    // R5: a clearing read with no new event drops the interrupt
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && !bus_we_i && bus_addr_i == ADDR_W'(5) && !sq_wp_fault_i && !sq_dec_done_i
         && !sq_nand_rdy_i && !sq_ctl_rdy_i) |=> !irq_o);

    // R7: an enabled event coinciding with a read still raises the interrupt
    a_r7_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sq_wp_fault_i && mask[0] && !bus_we_i) |=> irq_o);

    // R9: reset opcode pulses reset, not a command strobe
    a_r9_reset_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(0) && bus_wdata_i[7:0] == 8'hFF)
        |=> (seq_rst_o && !seq_cmd_stb_o));

    a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({seq_rst_o, seq_cmd_stb_o}));

endmodule

bind nfc_reg_front nfc_reg_front_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_we_i      (bus_we_i),
    .bus_re_i      (bus_re_i),
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .guard_open    (key_open),
    .mask          (ev_mask),
    .cfg           ({cfg_wprot_o, cfg_bigblk_o, cfg_longadr_o, cfg_bus16_o}),
    .sq_nand_rdy_i (sq_nand_rdy_i),
    .sq_ctl_rdy_i  (sq_ctl_rdy_i),
    .sq_dec_done_i (sq_dec_done_i),
    .sq_wp_fault_i (sq_wp_fault_i),
    .irq_o         (irq_o),
    .seq_rst_o     (seq_rst_o),
    .seq_cmd_stb_o (seq_cmd_stb_o)
);

// File: tb/nfc_reg_front_tb_top.sv
module nfc_reg_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, re = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nand_rdy = 0, ctl_rdy = 0, dec_done = 0, dec_err = 0, dec_fail = 0, wp = 0;
    logic [1:0]  dec_cnt = '0;
    logic        irq, srst, cstb, astb, b16, ladr, bblk, wprot, ce;
    logic [7:0]  code;
    logic [3:0]  wlo, whi, rlo, rhi;
    logic [2:0]  turn;
    logic [4:0]  busy;
    logic [1:0]  cea;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        logic [3:0]  adr;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    nfc_reg_front dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sq_nand_rdy_i(nand_rdy),
        .sq_ctl_rdy_i(ctl_rdy), .sq_dec_done_i(dec_done), .sq_dec_err_i(dec_err),
        .sq_dec_fail_i(dec_fail), .sq_dec_cnt_i(dec_cnt), .sq_wp_fault_i(wp),
        .irq_o(irq), .seq_rst_o(srst), .seq_cmd_stb_o(cstb), .seq_adr_stb_o(astb),
        .seq_code_o(code), .cfg_bus16_o(b16), .cfg_longadr_o(ladr), .cfg_bigblk_o(bblk),
        .cfg_wprot_o(wprot), .tm_wr_lo_o(wlo), .tm_wr_hi_o(whi), .tm_rd_lo_o(rlo),
        .tm_rd_hi_o(rhi), .tm_turn_o(turn), .tm_busy_o(busy), .tm_cea_o(cea),
        .ce_auto_o(ce)
    );

    // monitor: compares read data with the scoreboard
    always @(negedge clk) begin
        if (re) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read addr %0d actual %h expected none", addr, rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (rdata !== it.exp || addr !== it.adr) begin
                    errors++;
                    $display("FAIL %s read word %0d actual %h expected %h", it.tag, addr, rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1 we = 1; addr = a; wdata = d;
        @(posedge clk); #1 we = 0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        item_t it;
        it.exp = exp; it.adr = a; it.tag = tag;
        @(posedge clk); #1 re = 1; addr = a; exp_q.push_back(it);
        @(posedge clk); #1 re = 0;
    endtask

    task automatic pulse_wp();
        @(posedge clk); #1 wp = 1;
        @(posedge clk); #1 wp = 0;
    endtask

    task automatic pulse_dec(logic e, logic f, logic [1:0] c);
        @(posedge clk); #1 dec_done = 1; dec_err = e; dec_fail = f; dec_cnt = c;
        @(posedge clk); #1 dec_done = 0; dec_err = 0; dec_fail = 0; dec_cnt = 0;
    endtask

    function automatic logic [31:0] tim_word(int cea_v, int busy_v, int ta_v, int rh, int rl, int wh, int wl);
        return (32'(cea_v) << 24) | (32'(busy_v) << 19) | (32'(ta_v) << 16) |
               (32'(rh) << 12) | (32'(rl) << 8) | (32'(wh) << 4) | 32'(wl);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] tv;
        tv = tim_word(2, 21, 5, 12, 3, 9, 6);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R11 reset state
        chk("R11 irq", 32'(irq), 0);
        chk("R11 cfg", 32'({wprot, bblk, ladr, b16}), 0);
        chk("R11 timing", 32'({cea, busy, turn, rhi, rlo, whi, wlo}), 0);
        chk("R11 strobes", 32'({srst, cstb, astb, ce}), 0);
        rd(7, 0, "R11 lock closed");
        rd(4, 0, "R11 mask");
        rd(5, 0, "R11 status");
        rd(6, 0, "R11 raw");

        // R3 locked write ignored
        wr(2, 32'h6);
        chk("R3 cfg unchanged", 32'({wprot, bblk, ladr, b16}), 0);
        rd(7, 0, "R3 lock still closed");

        // R1 / R2 / R4 configuration
        wr(7, 32'h0000_A25E);
        rd(7, 1, "R1 key opens");
        wr(2, 32'h6);
        chk("R4 cfg bits", 32'({wprot, bblk, ladr, b16}), 32'b0110);
        rd(7, 0, "R2 auto relock");
        wr(2, 32'hF);
        chk("R3 second write ignored", 32'({wprot, bblk, ladr, b16}), 32'b0110);
        rd(2, 32'h6, "R4 cfg readback");

        // R1 wrong values close the guard
        wr(7, 32'h0000_A25E);
        wr(7, 32'h0000_1234);
        rd(7, 0, "R1 wrong key closes");
        wr(7, 32'h0001_A25E);
        rd(7, 0, "R1 upper bits must be zero");

        // R4 timing fields
        wr(7, 32'h0000_A25E);
        wr(3, tv);
        chk("R4 wr_lo", 32'(wlo), 6);
        chk("R4 wr_hi", 32'(whi), 9);
        chk("R4 rd_lo", 32'(rlo), 3);
        chk("R4 rd_hi", 32'(rhi), 12);
        chk("R4 turn", 32'(turn), 5);
        chk("R4 busy", 32'(busy), 21);
        chk("R4 cea", 32'(cea), 2);
        rd(3, tv, "R4 timing readback");
        rd(7, 0, "R2 relock after timing");
        wr(3, 32'h0);
        rd(3, tv, "R3 locked timing write ignored");

        // R5 / R6 clear on read
        wr(4, 32'h3F);
        rd(4, 32'h3F, "R6 mask readback");
        pulse_wp();
        chk("R6 irq on enabled event", 32'(irq), 1);
        rd(5, 32'h01, "R5 status wp bit");
        chk("R5 irq falls after read", 32'(irq), 0);
        rd(5, 32'h00, "R5 status cleared");

        // R7 event during clearing read
        pulse_wp();
        begin
            item_t it;
            it.exp = 32'h01; it.adr = 4'd5; it.tag = "R7 read returns old";
            @(posedge clk); #1 re = 1; addr = 5; dec_done = 1; exp_q.push_back(it);
            @(posedge clk); #1 re = 0; dec_done = 0;
        end
        chk("R7 irq still high", 32'(irq), 1);
        rd(5, 32'h02, "R7 coincident event kept");

        // R8 decode result
        pulse_dec(1, 0, 2'd3);
        rd(6, 32'h3C, "R8 raw err cnt3");
        rd(5, 32'h06, "R5 ecc and err bits");
        pulse_dec(0, 1, 2'd0);
        rd(6, 32'h44, "R8 raw failure");
        rd(5, 32'h0A, "R5 ecc and failure bits");

        // R5 / R8 ready edges
        @(posedge clk); #1 nand_rdy = 1;
        rd(6, 32'h45, "R8 raw nand level");
        rd(5, 32'h20, "R5 nand ready edge");
        @(posedge clk); #1 ctl_rdy = 1;
        rd(6, 32'h47, "R8 raw ctl level");
        rd(5, 32'h10, "R5 ctl ready edge");
        rd(5, 32'h00, "R5 held level gives no event");

        // R6 mask gating
        wr(4, 32'h01);
        pulse_dec(0, 0, 2'd0);
        chk("R6 masked event no irq", 32'(irq), 0);
        rd(6, 32'h07, "R8 raw clean decode");
        pulse_wp();
        chk("R6 enabled event irq", 32'(irq), 1);
        rd(5, 32'h03, "R6 masked event still latched");
        chk("R6 irq low after read", 32'(irq), 0);

        // R9 command, address, reset opcode
        wr(0, 32'h70);
        chk("R9 cmd strobe", 32'({srst, cstb, astb}), 32'b010);
        chk("R9 cmd byte", 32'(code), 32'h70);
        @(posedge clk); #1;
        chk("R9 cmd strobe one cycle", 32'(cstb), 0);
        wr(1, 32'h3C);
        chk("R9 addr strobe", 32'({srst, cstb, astb}), 32'b001);
        chk("R9 addr byte", 32'(code), 32'h3C);
        pulse_wp();
        chk("R9 irq before reset op", 32'(irq), 1);
        wr(0, 32'hFF);
        chk("R9 reset pulse", 32'({srst, cstb, astb}), 32'b100);
        chk("R9 reset clears irq", 32'(irq), 0);
        rd(6, 32'h03, "R9 decode result cleared");
        rd(5, 32'h00, "R9 events cleared");
        chk("R9 reset pulse one cycle", 32'(srst), 0);

        // R10 chip enable control
        wr(8, 32'h1);
        chk("R10 ce on", 32'(ce), 1);
        rd(8, 32'h1, "R10 ce readback");
        wr(8, 32'h0);
        chk("R10 ce off", 32'(ce), 0);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual %0d left expected 0", exp_q.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule